// File: doc/BRIEF.md
# Per-Sector ECC Status Scanner

After a page has been read through a hardware ECC engine, each sector of the page leaves a small status record behind. These records sit in a bank of 32-bit status words, four sectors per word. This block walks that bank when it receives a start strobe. For every sector it decides whether the sector is clean, correctable or lost. It hands each correctable sector (its index and its error count) to a downstream corrector, one request at a time. It keeps the largest error count seen in the page and reports that value when the scan ends.

The first lost sector stops the walk at once. The block then raises a failure flag and issues no more reads and no more requests. A status word that is entirely zero means four clean sectors, and the block steps past it in a single cycle. The status bank is reached through a combinational read port. The block drives the word address and a read strobe, and it takes the data in the same cycle.

Top module: `ecc_status_scanner`

## Requirements
- R1: At start the block latches the word count, which is the sector count divided by four, raised to at least one and capped at MAX_SECTORS/4. It then reads words 0, 1, 2 and so on, one read strobe per word, in ascending order.
- R2: Byte lane k of word w (bits 8k+7..8k) describes sector 4w+k. In each lane, bits [1:0] hold the status code and bits [6:2] hold the error count. Bit 7 carries no meaning of its own.
- R3: A lane whose code is 01 raises a correct request. The request carries the sector index 4w+k and the lane's count. It stays high with stable values until the corrector asserts its done input, and each request asks for exactly one sector.
- R4: A word that reads as zero is stepped past in the cycle it is read. A page whose words are all zero therefore ends with the done pulse N+1 cycles after start is sampled, where N is the word count.
- R5: A zero lane inside a nonzero word is clean and produces no request.
- R6: A nonzero lane whose code is not 01 sets the failure flag. The scan then ends: no later lane or word is read or requested.
- R7: The max-bitflip output holds the largest count among the sectors requested since start, and it is never below the count of the pending request.
- R8: A start accepted while the block is idle clears both the max-bitflip output and the failure flag. A start that arrives while a scan is running is ignored.
- R9: Done is a single-cycle pulse at the end of each scan. At that moment the max-bitflip output and the failure flag are final.
- R10: After reset, done, request and read strobe are low, and the max-bitflip output and the failure flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a scan (honoured only when idle) |
| sector_count | input | SCNT_W | Sectors in the page |
| rd_en | output | 1 | Status word read strobe |
| rd_addr | output | WADDR_W | Status word index |
| rd_data | input | 32 | Status word, valid in the same cycle |
| fix_valid | output | 1 | Correct request pending |
| fix_sector | output | SEC_W | Sector index of the request |
| fix_count | output | 5 | Error count of the request |
| fix_done | input | 1 | Corrector has finished the request |
| done | output | 1 | Scan finished (one cycle) |
| max_flips | output | 5 | Largest correctable count in the page |
| uncorrectable | output | 1 | A lost sector was found |

## Verification
Once start is sampled, the first read strobe is high in the next cycle. Each further word adds one cycle when it is zero. When it is nonzero, it adds one cycle per lane plus one cycle in the request state per correctable lane, and that request state lasts until fix_done is sampled. A correctable lane 0 therefore raises its request two cycles after its word is read. On an all-zero page, done is due in exactly the (N+1)-th cycle after start, and the bench counts falling edges to confirm both this and the cycle that follows, in which done must be low again. All other results are sampled on a falling edge in the cycle where done is seen, when max_flips and the failure flag must already be final. Requests and reads are recorded on falling edges, so each one is taken once in the cycle it is presented.

// File: rtl/ecs_pkg.sv
// Shared constants and types for the ECC status scanner.
// Assumes a 32-bit status word carrying four 8-bit sector lanes.
package ecs_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int LANE_W  = WORD_W / LANES;
    localparam int CODE_W  = 2;
    localparam int CNT_W   = 5;
    localparam int CNT_LSB = CODE_W;
    localparam logic [CODE_W-1:0] CODE_FIXABLE = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WORD,
        ST_LANE,
        ST_REQ,
        ST_FINISH
    } scan_state_t;
endpackage

// File: rtl/ecs_word_span.sv
// Converts a sector count into the index of the last status word to read.
// Assumes four sectors per word; at least one word, at most MAX_WORDS.
module ecs_word_span #(
    parameter int MAX_WORDS = 4,
    parameter int SCNT_W    = 5,
    parameter int WADDR_W   = 2
) (
    input  logic [SCNT_W-1:0]  sector_count,
    output logic [WADDR_W-1:0] last_word
);
    logic [SCNT_W-1:0] quarter;

    // Purpose: divide by four, then clamp into the range 1..MAX_WORDS.
    always_comb begin
        quarter = sector_count >> 2;
        if (quarter == '0) begin
            last_word = '0;
        end else if (quarter >= SCNT_W'(MAX_WORDS)) begin
            last_word = WADDR_W'(MAX_WORDS - 1);
        end else begin
            last_word = WADDR_W'(quarter - SCNT_W'(1));
        end
    end
endmodule

// File: rtl/ecs_lane_decode.sv
// Classifies one 8-bit sector lane as clean, fixable or lost, and extracts
// its error count. Assumes code in bits [1:0] and count in bits [6:2].
module ecs_lane_decode
    import ecs_pkg::*;
(
    input  logic [LANE_W-1:0] lane,
    output logic              is_clean,
    output logic              is_fixable,
    output logic [CNT_W-1:0]  count
);
    // Purpose: decode the lane fields.
    always_comb begin
        is_clean   = (lane == '0);
        is_fixable = (lane[CODE_W-1:0] == CODE_FIXABLE);
        count      = lane[CNT_LSB +: CNT_W];
    end
endmodule

// File: rtl/ecs_peak.sv
// Running maximum of error counts. Assumes clear and load never coincide
// in a way that matters: clear wins.
module ecs_peak #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] peak
);
    // Purpose: hold the largest value loaded since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (clear) begin
            peak <= '0;
        end else if (load && (value > peak)) begin
            peak <= value;
        end
    end
endmodule

// File: rtl/ecc_status_scanner.sv
// Walks a bank of packed per-sector ECC status words, issues one correct
// request per fixable sector with a done handshake, tracks the peak error
// count, and aborts on the first lost sector.
// Assumes the status read port returns data combinationally for rd_addr.
module ecc_status_scanner
    import ecs_pkg::*;
#(
    parameter  int MAX_SECTORS = 16,
    localparam int MAX_WORDS   = MAX_SECTORS / LANES,
    localparam int WADDR_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int LIDX_W      = $clog2(LANES),
    localparam int SEC_W       = WADDR_W + LIDX_W,
    localparam int SCNT_W      = $clog2(MAX_SECTORS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SCNT_W-1:0]  sector_count,
    output logic               rd_en,
    output logic [WADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               fix_valid,
    output logic [SEC_W-1:0]   fix_sector,
    output logic [CNT_W-1:0]   fix_count,
    input  logic               fix_done,
    output logic               done,
    output logic [CNT_W-1:0]   max_flips,
    output logic               uncorrectable
);
    scan_state_t        state;
    logic [WADDR_W-1:0] word_idx;
    logic [WADDR_W-1:0] last_q;
    logic [WADDR_W-1:0] span_last;
    logic [LIDX_W-1:0]  lane_idx;
    logic [WORD_W-1:0]  word_q;
    logic [SEC_W-1:0]   sec_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               fail_q;

    logic [LANES-1:0]   l_clean;
    logic [LANES-1:0]   l_fix;
    logic [CNT_W-1:0]   l_cnt [LANES];

    logic               cur_clean;
    logic               cur_fix;
    logic [CNT_W-1:0]   cur_cnt;
    logic               at_last_lane;
    logic               at_last_word;
    logic               scan_idle;
    logic               take_start;
    logic               peak_load;

    ecs_word_span #(
        .MAX_WORDS (MAX_WORDS),
        .SCNT_W    (SCNT_W),
        .WADDR_W   (WADDR_W)
    ) u_span (
        .sector_count (sector_count),
        .last_word    (span_last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ecs_lane_decode u_dec (
            .lane       (word_q[g*LANE_W +: LANE_W]),
            .is_clean   (l_clean[g]),
            .is_fixable (l_fix[g]),
            .count      (l_cnt[g])
        );
    end

    // Purpose: select the decode of the lane under examination.
    always_comb begin
        cur_clean    = l_clean[lane_idx];
        cur_fix      = l_fix[lane_idx];
        cur_cnt      = l_cnt[lane_idx];
        at_last_lane = (lane_idx == LIDX_W'(LANES - 1));
        at_last_word = (word_idx == last_q);
        scan_idle    = (state == ST_IDLE);
        take_start   = scan_idle && start;
        peak_load    = (state == ST_LANE) && !cur_clean && cur_fix;
    end

    ecs_peak #(
        .CNT_W (CNT_W)
    ) u_peak (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take_start),
        .load  (peak_load),
        .value (cur_cnt),
        .peak  (max_flips)
    );

    // Purpose: scan sequencer, one word read or one lane decision per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            word_idx <= '0;
            last_q   <= '0;
            lane_idx <= '0;
            word_q   <= '0;
            sec_q    <= '0;
            cnt_q    <= '0;
            fail_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        last_q   <= span_last;
                        word_idx <= '0;
                        fail_q   <= 1'b0;
                        state    <= ST_WORD;
                    end
                end
                ST_WORD: begin
                    word_q   <= rd_data;
                    lane_idx <= '0;
                    if (rd_data != '0) begin
                        state <= ST_LANE;
                    end else if (at_last_word) begin
                        state <= ST_FINISH;
                    end else begin
                        word_idx <= word_idx + WADDR_W'(1);
                        state    <= ST_WORD;
                    end
                end
                ST_LANE: begin
                    if (!cur_clean && cur_fix) begin
                        sec_q <= {word_idx, lane_idx};
                        cnt_q <= cur_cnt;
                        state <= ST_REQ;
                    end else if (!cur_clean) begin
                        fail_q <= 1'b1;
                        state  <= ST_FINISH;
                    end else if (!at_last_lane) begin
                        lane_idx <= lane_idx + LIDX_W'(1);
                    end else if (at_last_word) begin
                        state <= ST_FINISH;
                    end else begin
                        word_idx <= word_idx + WADDR_W'(1);
                        state    <= ST_WORD;
                    end
                end
                ST_REQ: begin
                    if (fix_done) begin
                        if (!at_last_lane) begin
                            lane_idx <= lane_idx + LIDX_W'(1);
                            state    <= ST_LANE;
                        end else if (at_last_word) begin
                            state <= ST_FINISH;
                        end else begin
                            word_idx <= word_idx + WADDR_W'(1);
                            state    <= ST_WORD;
                        end
                    end
                end
                ST_FINISH: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Purpose: drive the block outputs from the sequencer state.
    always_comb begin
        rd_en         = (state == ST_WORD);
        rd_addr       = word_idx;
        fix_valid     = (state == ST_REQ);
        fix_sector    = sec_q;
        fix_count     = cnt_q;
        done          = (state == ST_FINISH);
        uncorrectable = fail_q;
    end
endmodule

// File: rtl/ecs_checker.sv
// Temporal checks for the ECC status scanner, attached by bind.
// Assumes synchronous active-low reset held for at least one edge.
module ecs_checker #(
    parameter int SEC_W = 4,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             idle,
    input logic             rd_en,
    input logic             fix_valid,
    input logic [SEC_W-1:0] fix_sector,
    input logic [CNT_W-1:0] fix_count,
    input logic             fix_done,
    input logic             done,
    input logic [CNT_W-1:0] max_flips,
    input logic             uncorrectable
);
    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a pending request holds its values until the corrector finishes
    a_r3_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_valid && !fix_done) |=> (fix_valid && $stable(fix_sector) && $stable(fix_count)));

    // R7: the peak covers the pending request
    a_r7_peak_covers: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> (max_flips >= fix_count));

    // R7: the peak never falls inside a scan
    a_r7_peak_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && idle) |=> (max_flips >= $past(max_flips)));

    // R8: an accepted start clears peak and failure flag
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle) |=> (max_flips == '0 && !uncorrectable));

    // R6: after a lost sector no read and no request follow
    a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |-> (!fix_valid && !rd_en));
endmodule

bind ecc_status_scanner ecs_checker #(
    .SEC_W (SEC_W),
    .CNT_W (ecs_pkg::CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .idle          (scan_idle),
    .rd_en         (rd_en),
    .fix_valid     (fix_valid),
    .fix_sector    (fix_sector),
    .fix_count     (fix_count),
    .fix_done      (fix_done),
    .done          (done),
    .max_flips     (max_flips),
    .uncorrectable (uncorrectable)
);

// File: tb/sim_ecc_status_scanner.sv
// Sweep bench: every sector count 0..16 against eight status patterns.
module sim_ecc_status_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  sector_count = '0;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        fix_valid;
    logic [3:0]  fix_sector;
    logic [4:0]  fix_count;
    logic        fix_done = 1'b0;
    logic        done;
    logic [4:0]  max_flips;
    logic        uncorrectable;

    logic [31:0] mem [4];
    int checks = 0;
    int errors = 0;
    int resp_delay = 0;
    int got_n = 0;
    int got_sec [64];
    int got_cnt [64];
    int rd_n = 0;
    int rd_log [64];
    int exp_n, exp_rd_n, exp_max, exp_fail;
    int exp_sec [64];
    int exp_cnt [64];
    int exp_rd [64];

    always #5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    ecc_status_scanner #(.MAX_SECTORS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_count(sector_count),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .fix_valid(fix_valid), .fix_sector(fix_sector), .fix_count(fix_count),
        .fix_done(fix_done), .done(done), .max_flips(max_flips),
        .uncorrectable(uncorrectable)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Corrector model: takes each request once, answers after resp_delay cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (fix_valid) begin
                if (got_n < 64) begin
                    got_sec[got_n] = int'(fix_sector);
                    got_cnt[got_n] = int'(fix_count);
                end
                got_n++;
                repeat (resp_delay) @(negedge clk);
                fix_done = 1'b1;
                @(negedge clk);
                fix_done = 1'b0;
            end
        end
    end

    // Read recorder.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) begin
                if (rd_n < 64) rd_log[rd_n] = int'(rd_addr);
                rd_n++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9: watchdog expired, actual no finish expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [7:0] gen_lane(int seed, int w, int l);
        int h;
        logic [4:0] c;
        h = (seed * 73 + w * 29 + l * 13 + 7) % 23;
        if (seed == 0) return 8'h00;
        if (seed == 7) return {1'b1, 5'(w * 4 + l + 16), 2'b01};
        if (seed == 6) return (w == 0 && l == 0) ? 8'h02 : {1'b0, 5'(l + 3), 2'b01};
        if (seed >= 2 && ((seed + w) % 3) == 0) return 8'h00;
        if (h < 7) return 8'h00;
        c = 5'((h * 3) % 32);
        if (h < 20) return {1'(h % 2), c, 2'b01};
        if (h == 20) return {1'b0, 5'd20, 2'b00};
        if (h == 21) return {1'b1, 5'd9, 2'b11};
        return {1'b0, 5'd0, 2'b10};
    endfunction

    // Reference outcome from the requirement text.
    task automatic model(int nsec);
        int nw;
        logic [7:0] b;
        nw = nsec / 4;
        if (nw == 0) nw = 1;
        if (nw > 4) nw = 4;
        exp_n = 0; exp_rd_n = 0; exp_max = 0; exp_fail = 0;
        for (int w = 0; w < nw && !exp_fail; w++) begin
            exp_rd[exp_rd_n++] = w;
            if (mem[w] == 32'h0) continue;
            for (int l = 0; l < 4 && !exp_fail; l++) begin
                b = mem[w][l*8 +: 8];
                if (b == 8'h00) continue;
                if (b[1:0] == 2'b01) begin
                    exp_sec[exp_n] = w * 4 + l;
                    exp_cnt[exp_n] = int'(b[6:2]);
                    if (int'(b[6:2]) > exp_max) exp_max = int'(b[6:2]);
                    exp_n++;
                end else begin
                    exp_fail = 1;
                end
            end
        end
    endtask

    task automatic run_page(int nsec, int seed, int delay, bit poke);
        int cyc;
        int nw;
        bit poked;
        for (int w = 0; w < 4; w++)
            for (int l = 0; l < 4; l++)
                mem[w][l*8 +: 8] = gen_lane(seed, w, l);
        model(nsec);
        nw = nsec / 4;
        if (nw == 0) nw = 1;
        if (nw > 4) nw = 4;
        resp_delay = delay;
        @(negedge clk);
        got_n = 0;
        rd_n = 0;
        start = 1'b1;
        sector_count = 5'(nsec);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        poked = 1'b0;
        while (!done && cyc < 3000) begin
            if (poke && fix_valid && !poked) begin
                start = 1'b1;
                sector_count = 5'd4;
                poked = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check("R9 done reached", int'(done), 1);
        if (seed == 0) check("R4 all-zero page done cycle", cyc, nw + 1);
        check("R3 request count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check("R2 sector index", got_sec[i], exp_sec[i]);
            check("R3 request count field", got_cnt[i], exp_cnt[i]);
        end
        check("R1 read count", rd_n, exp_rd_n);
        for (int i = 0; i < exp_rd_n && i < rd_n; i++)
            check("R1 read order", rd_log[i], exp_rd[i]);
        check("R7 max bitflips", int'(max_flips), exp_max);
        check("R6 uncorrectable flag", int'(uncorrectable), exp_fail);
        @(negedge clk);
        check("R9 done single cycle", int'(done), 0);
    endtask

    initial begin
        for (int w = 0; w < 4; w++) mem[w] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 done after reset", int'(done), 0);
        check("R10 request after reset", int'(fix_valid), 0);
        check("R10 read strobe after reset", int'(rd_en), 0);
        check("R10 max after reset", int'(max_flips), 0);
        check("R10 flag after reset", int'(uncorrectable), 0);

        // Sweep: seeds 1..7 then 0 so a clear page follows failures and peaks (R8, R5).
        for (int s = 0; s < 8; s++) begin
            for (int n = 0; n <= 16; n++) begin
                run_page(n, (s + 1) % 8, (s + n) % 3, 1'b0);
            end
        end

        // R8: a start while a request is pending is ignored.
        run_page(16, 7, 3, 1'b1);
        // R6: lost first sector after a full peak page, flag and peak restart.
        run_page(16, 6, 0, 1'b0);
        run_page(8, 0, 0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule